// File: doc/BRIEF.md
# Disk Controller Error Status Capture Buffer

This block keeps a twelve-byte record of what went wrong during the current disk command. While a command runs, the error detectors raise coded strobes, and the position logic loads the target and the observed cylinder, head and sector. The retry logic pulses an increment for each retry. Error bits collect into one hard error word and one soft error byte. Position fields keep the most recent value loaded, and the retry count climbs but stops at its ceiling.

Every command start clears the record, except a start of the transfer command (function code 01h). That command leaves the record as it is and streams the twelve bytes out, lowest index first, over a valid/ready byte interface. A separate sticky flag tells the host whether an ECC error in this command was uncorrectable. That flag is the hard-or-soft classification of the ECC bits.

Top module: `errstat_buf`

## Requirements
- R1: After reset, and one cycle after a command start whose function code is not 01h, all twelve bytes read as 00h and `ecc_hard` is 0. Events presented in the same cycle as such a clearing start are discarded.
- R2: A command start with function code 01h does not clear the record. Bits set before it stay set, and later events keep accumulating on top of them.
- R3: A hard error strobe with code c in 3..15 sets bit c of the hard word. Byte 0 carries word bits 7:0 and byte 1 carries bits 15:8. Codes 0..2 are reserved and change nothing. Set bits stay set until the next clearing start.
- R4: A soft error strobe with code c in 3..7 sets bit c of byte 2. Codes 0..2 change nothing.
- R5: An ECC strobe sets byte 2 bit 3 (data field) when `ecc_id_field`=0, or byte 2 bit 4 (ID field) when it is 1. If `ecc_uncorr` is 1 on that strobe, `ecc_hard` rises one cycle later and stays high until a clearing start.
- R6: A target load writes cylinder bits 7:0 to byte 3, cylinder bits 15:8 to byte 4, head/volume to byte 5 and sector to byte 6.
- R7: An observed-position load writes cylinder bits 7:0 to byte 7, {flags[3:0], cylinder[11:8]} to byte 8, head/volume to byte 9 and sector to byte 10. The last load wins.
- R8: An observed-position load with flags[0] (alternate track) and flags[1] (defective alternate) both set also sets hard word bit 6 (illegal format).
- R9: Byte 11 counts retry increments and holds at FFh instead of wrapping.
- R10: After a transfer start, `rd_valid` is high from the next cycle. Bytes 0..11 appear in order, `rd_idx` gives the byte index, and the interface advances only on a cycle with `rd_valid` and `rd_ready` both high. `rd_last` marks byte 11, and `rd_valid` falls after that byte is accepted. A transfer start while streaming is ignored.
- R11: Streaming the record out changes none of its contents, so two readouts in a row give identical bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command start strobe |
| cmd_func | input | FUNC_W | Function code of the starting command |
| hard_evt | input | 1 | Hard error strobe |
| hard_code | input | 4 | Hard word bit index |
| soft_evt | input | 1 | Soft error strobe |
| soft_code | input | 3 | Soft byte bit index |
| ecc_evt | input | 1 | ECC error strobe |
| ecc_id_field | input | 1 | 1: ID field ECC, 0: data field ECC |
| ecc_uncorr | input | 1 | ECC error is uncorrectable |
| des_load | input | 1 | Load target position |
| des_cyl | input | 16 | Target cylinder |
| des_head | input | 8 | Target head and volume |
| des_sec | input | 8 | Target sector |
| act_load | input | 1 | Load observed position |
| act_cyl | input | 12 | Observed cylinder |
| act_flags | input | 4 | Track flags (bit0 alternate, bit1 defective alternate) |
| act_head | input | 8 | Observed head and volume |
| act_sec | input | 8 | Observed sector |
| retry_inc | input | 1 | Retry increment |
| ecc_hard | output | 1 | Sticky uncorrectable ECC indication |
| rd_valid | output | 1 | Readout byte valid |
| rd_ready | input | 1 | Readout byte accepted |
| rd_data | output | 8 | Readout byte |
| rd_idx | output | 4 | Index of the byte on rd_data |
| rd_last | output | 1 | Byte 11 is on rd_data |

## Verification
Every capture, clear and count lands one clock after its strobe, so its effect can show on the readout from the following cycle. `ecc_hard` is registered, and the bench checks it on the falling edge that follows the strobe's rising edge. A readout starts with `rd_valid` one cycle after the transfer start, and each accepted byte moves `rd_idx` on at the next edge. The bench drives all inputs on falling edges and compares each byte half a cycle after the edge that put it out. Stalled bytes are checked again after the stalling edge.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int BUF_BYTES = 12;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int HARD_W    = 16;
  localparam int SOFT_W    = 8;
  localparam int RSV_BITS  = 3;
  localparam int HCODE_W   = $clog2(HARD_W);
  localparam int SCODE_W   = $clog2(SOFT_W);
  localparam int FMT_BIT   = 6;
  localparam int ECC_DBIT  = 3;
  localparam int ECC_IBIT  = 4;
  localparam int DCYL_W    = 16;
  localparam int ACYL_W    = 12;
  localparam int FLAG_W    = 4;
  localparam int RETRY_W   = 8;

  typedef enum logic {RD_IDLE, RD_SEND} rd_state_e;
  typedef logic [BUF_BYTES-1:0][7:0] buf_t;
endpackage

// File: rtl/errstat_decode.sv
module errstat_decode
  import errstat_pkg::*;
(
  input  logic               hard_evt,
  input  logic [HCODE_W-1:0] hard_code,
  input  logic               soft_evt,
  input  logic [SCODE_W-1:0] soft_code,
  input  logic               ecc_evt,
  input  logic               ecc_id_field,
  input  logic               ecc_uncorr,
  input  logic               act_load,
  input  logic [FLAG_W-1:0]  act_flags,
  output logic [HARD_W-1:0]  hard_set,
  output logic [SOFT_W-1:0]  soft_set,
  output logic               ecc_hard_set
);
  logic fmt_conflict;
  assign fmt_conflict = act_load && act_flags[0] && act_flags[1];

  genvar g;
  generate
    for (g = 0; g < HARD_W; g++) begin : g_hard
      if (g < RSV_BITS) begin : g_rsv
        assign hard_set[g] = 1'b0;
      end else if (g == FMT_BIT) begin : g_fmt
        assign hard_set[g] = (hard_evt && hard_code == HCODE_W'(g)) || fmt_conflict;
      end else begin : g_evt
        assign hard_set[g] = hard_evt && hard_code == HCODE_W'(g);
      end
    end
    for (g = 0; g < SOFT_W; g++) begin : g_soft
      if (g < RSV_BITS) begin : g_rsv
        assign soft_set[g] = 1'b0;
      end else if (g == ECC_DBIT) begin : g_ecd
        assign soft_set[g] = (soft_evt && soft_code == SCODE_W'(g)) ||
                             (ecc_evt && !ecc_id_field);
      end else if (g == ECC_IBIT) begin : g_eci
        assign soft_set[g] = (soft_evt && soft_code == SCODE_W'(g)) ||
                             (ecc_evt && ecc_id_field);
      end else begin : g_evt
        assign soft_set[g] = soft_evt && soft_code == SCODE_W'(g);
      end
    end
  endgenerate

  assign ecc_hard_set = ecc_evt && ecc_uncorr;
endmodule

// File: rtl/errstat_store.sv
module errstat_store
  import errstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [HARD_W-1:0] hard_set,
  input  logic [SOFT_W-1:0] soft_set,
  input  logic              ecc_hard_set,
  input  logic              des_load,
  input  logic [DCYL_W-1:0] des_cyl,
  input  logic [7:0]        des_head,
  input  logic [7:0]        des_sec,
  input  logic              act_load,
  input  logic [ACYL_W-1:0] act_cyl,
  input  logic [FLAG_W-1:0] act_flags,
  input  logic [7:0]        act_head,
  input  logic [7:0]        act_sec,
  input  logic              retry_inc,
  output buf_t              buf_bytes,
  output logic              ecc_hard
);
  logic [HARD_W-1:0]  hard_q, hard_d;
  logic [SOFT_W-1:0]  soft_q, soft_d;
  logic [DCYL_W-1:0]  dcyl_q, dcyl_d;
  logic [7:0]         dhead_q, dhead_d, dsec_q, dsec_d;
  logic [ACYL_W-1:0]  acyl_q, acyl_d;
  logic [FLAG_W-1:0]  aflg_q, aflg_d;
  logic [7:0]         ahead_q, ahead_d, asec_q, asec_d;
  logic [RETRY_W-1:0] retry_q, retry_d;
  logic               ecc_q, ecc_d;
  logic               upd_en;

  assign upd_en = clear || (|hard_set) || (|soft_set) || ecc_hard_set ||
                  des_load || act_load || retry_inc;

  always_comb begin
    hard_d  = hard_q;
    soft_d  = soft_q;
    dcyl_d  = dcyl_q;
    dhead_d = dhead_q;
    dsec_d  = dsec_q;
    acyl_d  = acyl_q;
    aflg_d  = aflg_q;
    ahead_d = ahead_q;
    asec_d  = asec_q;
    retry_d = retry_q;
    ecc_d   = ecc_q;
    if (clear) begin
      hard_d  = '0;
      soft_d  = '0;
      dcyl_d  = '0;
      dhead_d = '0;
      dsec_d  = '0;
      acyl_d  = '0;
      aflg_d  = '0;
      ahead_d = '0;
      asec_d  = '0;
      retry_d = '0;
      ecc_d   = 1'b0;
    end else begin
      hard_d = hard_q | hard_set;
      soft_d = soft_q | soft_set;
      ecc_d  = ecc_q | ecc_hard_set;
      if (des_load) begin
        dcyl_d  = des_cyl;
        dhead_d = des_head;
        dsec_d  = des_sec;
      end
      if (act_load) begin
        acyl_d  = act_cyl;
        aflg_d  = act_flags;
        ahead_d = act_head;
        asec_d  = act_sec;
      end
      if (retry_inc && retry_q != '1) begin
        retry_d = retry_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q  <= '0;
      soft_q  <= '0;
      dcyl_q  <= '0;
      dhead_q <= '0;
      dsec_q  <= '0;
      acyl_q  <= '0;
      aflg_q  <= '0;
      ahead_q <= '0;
      asec_q  <= '0;
      retry_q <= '0;
      ecc_q   <= 1'b0;
    end else if (upd_en) begin
      hard_q  <= hard_d;
      soft_q  <= soft_d;
      dcyl_q  <= dcyl_d;
      dhead_q <= dhead_d;
      dsec_q  <= dsec_d;
      acyl_q  <= acyl_d;
      aflg_q  <= aflg_d;
      ahead_q <= ahead_d;
      asec_q  <= asec_d;
      retry_q <= retry_d;
      ecc_q   <= ecc_d;
    end
  end

  always_comb begin
    buf_bytes[0]  = hard_q[7:0];
    buf_bytes[1]  = hard_q[15:8];
    buf_bytes[2]  = soft_q;
    buf_bytes[3]  = dcyl_q[7:0];
    buf_bytes[4]  = dcyl_q[15:8];
    buf_bytes[5]  = dhead_q;
    buf_bytes[6]  = dsec_q;
    buf_bytes[7]  = acyl_q[7:0];
    buf_bytes[8]  = {aflg_q, acyl_q[ACYL_W-1:8]};
    buf_bytes[9]  = ahead_q;
    buf_bytes[10] = asec_q;
    buf_bytes[11] = retry_q;
  end

  assign ecc_hard = ecc_q;
endmodule

// File: rtl/errstat_reader.sv
module errstat_reader
  import errstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  buf_t             buf_bytes,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_BYTES - 1);

  rd_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             st_en;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      RD_IDLE: begin
        if (start) begin
          st_d  = RD_SEND;
          idx_d = '0;
        end
      end
      RD_SEND: begin
        if (rd_ready) begin
          if (idx_q == LAST_IDX) begin
            st_d  = RD_IDLE;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = RD_IDLE;
        idx_d = '0;
      end
    endcase
  end

  assign st_en = (st_q == RD_IDLE) ? start : rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      idx_q <= '0;
    end else if (st_en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign rd_valid = (st_q == RD_SEND);
  assign rd_idx   = idx_q;
  assign rd_last  = rd_valid && (idx_q == LAST_IDX);
  assign rd_data  = buf_bytes[idx_q];
endmodule

// File: rtl/errstat_buf.sv
module errstat_buf
  import errstat_pkg::*;
#(
  parameter int                FUNC_W    = 8,
  parameter logic [FUNC_W-1:0] XFER_CODE = FUNC_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic [FUNC_W-1:0]  cmd_func,
  input  logic               hard_evt,
  input  logic [HCODE_W-1:0] hard_code,
  input  logic               soft_evt,
  input  logic [SCODE_W-1:0] soft_code,
  input  logic               ecc_evt,
  input  logic               ecc_id_field,
  input  logic               ecc_uncorr,
  input  logic               des_load,
  input  logic [DCYL_W-1:0]  des_cyl,
  input  logic [7:0]         des_head,
  input  logic [7:0]         des_sec,
  input  logic               act_load,
  input  logic [ACYL_W-1:0]  act_cyl,
  input  logic [FLAG_W-1:0]  act_flags,
  input  logic [7:0]         act_head,
  input  logic [7:0]         act_sec,
  input  logic               retry_inc,
  output logic               ecc_hard,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [7:0]         rd_data,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               rd_last
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              is_xfer, clear, xfer_start;
  logic [HARD_W-1:0] hard_set;
  logic [SOFT_W-1:0] soft_set;
  logic              ecc_hard_set;
  buf_t              buf_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign is_xfer    = (cmd_func == XFER_CODE);
  assign clear      = cmd_start && !is_xfer;
  assign xfer_start = cmd_start && is_xfer;

  errstat_decode u_dec (
    .hard_evt     (hard_evt),
    .hard_code    (hard_code),
    .soft_evt     (soft_evt),
    .soft_code    (soft_code),
    .ecc_evt      (ecc_evt),
    .ecc_id_field (ecc_id_field),
    .ecc_uncorr   (ecc_uncorr),
    .act_load     (act_load),
    .act_flags    (act_flags),
    .hard_set     (hard_set),
    .soft_set     (soft_set),
    .ecc_hard_set (ecc_hard_set)
  );

  errstat_store u_store (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clear        (clear),
    .hard_set     (hard_set),
    .soft_set     (soft_set),
    .ecc_hard_set (ecc_hard_set),
    .des_load     (des_load),
    .des_cyl      (des_cyl),
    .des_head     (des_head),
    .des_sec      (des_sec),
    .act_load     (act_load),
    .act_cyl      (act_cyl),
    .act_flags    (act_flags),
    .act_head     (act_head),
    .act_sec      (act_sec),
    .retry_inc    (retry_inc),
    .buf_bytes    (buf_bytes),
    .ecc_hard     (ecc_hard)
  );

  errstat_reader u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (xfer_start),
    .buf_bytes (buf_bytes),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .rd_last   (rd_last)
  );
endmodule

// File: rtl/errstat_chk.sv
module errstat_chk
  import errstat_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             clear,
  input logic             xfer_start,
  input logic             act_load,
  input logic [FLAG_W-1:0] act_flags,
  input buf_t             buf_bytes,
  input logic             ecc_hard,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_last
);
  logic [HARD_W-1:0] hard_w;
  assign hard_w = {buf_bytes[1], buf_bytes[0]};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear |=> (buf_bytes == '0 && !ecc_hard)); // R1
  AST_XFER_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_start |=> ((hard_w & $past(hard_w)) == $past(hard_w))); // R2
  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clear |=> ((hard_w & $past(hard_w)) == $past(hard_w))); // R3
  AST_ECC_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ecc_hard && !clear) |=> ecc_hard); // R5
  AST_FMT_CONFLICT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_load && act_flags[1:0] == 2'b11 && !clear) |=> buf_bytes[0][FMT_BIT]); // R8
  AST_RETRY_SAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_bytes[BUF_BYTES-1] == 8'hFF && !clear) |=> buf_bytes[BUF_BYTES-1] == 8'hFF); // R9
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && rd_ready && !rd_last) |=> (rd_valid && rd_idx == $past(rd_idx) + 1'b1)); // R10
  AST_RD_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && rd_ready && rd_last) |=> !rd_valid); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_idx))); // R10
  AST_RD_LAST_IDX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_last |-> (rd_valid && rd_idx == IDX_W'(BUF_BYTES - 1))); // R10
endmodule

bind errstat_buf errstat_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clear      (clear),
  .xfer_start (xfer_start),
  .act_load   (act_load),
  .act_flags  (act_flags),
  .buf_bytes  (buf_bytes),
  .ecc_hard   (ecc_hard),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_idx     (rd_idx),
  .rd_last    (rd_last)
);

// File: tb/errstat_buf_tb_top.sv
`timescale 1ns/1ps
module errstat_buf_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cmd_start;
  logic [7:0]  cmd_func;
  logic        hard_evt;
  logic [3:0]  hard_code;
  logic        soft_evt;
  logic [2:0]  soft_code;
  logic        ecc_evt, ecc_id_field, ecc_uncorr;
  logic        des_load;
  logic [15:0] des_cyl;
  logic [7:0]  des_head, des_sec;
  logic        act_load;
  logic [11:0] act_cyl;
  logic [3:0]  act_flags;
  logic [7:0]  act_head, act_sec;
  logic        retry_inc;
  logic        ecc_hard, rd_valid, rd_ready, rd_last;
  logic [7:0]  rd_data;
  logic [3:0]  rd_idx;

  errstat_buf dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_func(cmd_func),
    .hard_evt(hard_evt), .hard_code(hard_code), .soft_evt(soft_evt), .soft_code(soft_code),
    .ecc_evt(ecc_evt), .ecc_id_field(ecc_id_field), .ecc_uncorr(ecc_uncorr),
    .des_load(des_load), .des_cyl(des_cyl), .des_head(des_head), .des_sec(des_sec),
    .act_load(act_load), .act_cyl(act_cyl), .act_flags(act_flags), .act_head(act_head),
    .act_sec(act_sec), .retry_inc(retry_inc), .ecc_hard(ecc_hard), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_idx(rd_idx), .rd_last(rd_last)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_b [12];
  logic exp_ecc;
  int clr_sel = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 12; i++) exp_b[i] = 8'h00;
    exp_ecc = 1'b0;
  endtask

  task automatic clear_cmd();
    logic [7:0] codes [4];
    codes[0] = 8'h20; codes[1] = 8'h00; codes[2] = 8'h02; codes[3] = 8'hFF;
    cmd_start = 1'b1; cmd_func = codes[clr_sel % 4]; clr_sel++;
    cyc();
    cmd_start = 1'b0;
    model_clear();
  endtask

  task automatic pulse_hard(input int c);
    hard_evt = 1'b1; hard_code = 4'(c);
    cyc();
    hard_evt = 1'b0;
    if (c >= 3) begin
      if (c < 8) exp_b[0][c] = 1'b1; else exp_b[1][c-8] = 1'b1;
    end
  endtask

  task automatic readout(input string tag, input bit stall, input bit inject);
    cmd_start = 1'b1; cmd_func = 8'h01; rd_ready = 1'b0;
    cyc();
    cmd_start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (stall && (i % 3 == 1)) begin
        cyc();
        chk(tag, "valid held under stall", int'(rd_valid), 1);
        chk(tag, "index held under stall", int'(rd_idx), i);
      end
      chk(tag, "rd_valid", int'(rd_valid), 1);
      chk(tag, "rd_idx", int'(rd_idx), i);
      chk(tag, $sformatf("byte %0d", i), int'(rd_data), int'(exp_b[i]));
      chk(tag, "rd_last", int'(rd_last), (i == 11) ? 1 : 0);
      rd_ready = 1'b1;
      if (inject && i == 5) begin
        cmd_start = 1'b1; cmd_func = 8'h01;
      end
      cyc();
      rd_ready = 1'b0;
      cmd_start = 1'b0;
    end
    chk(tag, "rd_valid after last byte", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_start = 0; cmd_func = 0; hard_evt = 0; hard_code = 0;
    soft_evt = 0; soft_code = 0; ecc_evt = 0; ecc_id_field = 0; ecc_uncorr = 0;
    des_load = 0; des_cyl = 0; des_head = 0; des_sec = 0; act_load = 0; act_cyl = 0;
    act_flags = 0; act_head = 0; act_sec = 0; retry_inc = 0; rd_ready = 0;
    model_clear();
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1: reset state
    chk("R1", "rd_valid after reset", int'(rd_valid), 0);
    chk("R1", "ecc_hard after reset", int'(ecc_hard), 0);
    readout("R1", 1'b0, 1'b0);

    // R3: every hard code, including reserved 0..2
    for (int c = 0; c < 16; c++) begin
      clear_cmd();
      pulse_hard(c);
      readout("R3", c[0], 1'b0);
    end

    // R4: every soft code
    for (int c = 0; c < 8; c++) begin
      clear_cmd();
      soft_evt = 1'b1; soft_code = 3'(c);
      cyc();
      soft_evt = 1'b0;
      if (c >= 3) exp_b[2][c] = 1'b1;
      readout("R4", c[1], 1'b0);
    end

    // R5: ECC field selection and hard/soft class
    for (int k = 0; k < 4; k++) begin
      clear_cmd();
      ecc_evt = 1'b1; ecc_id_field = k[0]; ecc_uncorr = k[1];
      cyc();
      ecc_evt = 1'b0; ecc_uncorr = 1'b0;
      exp_b[2][k[0] ? 4 : 3] = 1'b1;
      exp_ecc = k[1];
      chk("R5", "ecc_hard after strobe", int'(ecc_hard), int'(exp_ecc));
      readout("R5", 1'b0, 1'b0);
      chk("R5", "ecc_hard held over readout", int'(ecc_hard), int'(exp_ecc));
    end
    clear_cmd();
    chk("R5", "ecc_hard after clear", int'(ecc_hard), 0);

    // R6: target position patterns
    for (int k = 0; k < 6; k++) begin
      clear_cmd();
      des_load = 1'b1;
      des_cyl  = 16'((k + 1) * 16'h2F13);
      des_head = 8'((k * 37) + 5);
      des_sec  = 8'(255 - k * 41);
      cyc();
      des_load = 1'b0;
      exp_b[3] = des_cyl[7:0]; exp_b[4] = des_cyl[15:8];
      exp_b[5] = des_head; exp_b[6] = des_sec;
      readout("R6", k[0], 1'b0);
    end

    // R7 / R8: observed position over all flag values
    for (int f = 0; f < 16; f++) begin
      clear_cmd();
      act_load = 1'b1;
      act_cyl  = 12'(f * 273 + 9);
      act_flags = 4'(f);
      act_head = 8'(f * 11);
      act_sec  = 8'(f * 13 + 1);
      cyc();
      act_load = 1'b0;
      exp_b[7] = act_cyl[7:0];
      exp_b[8] = {act_flags, act_cyl[11:8]};
      exp_b[9] = act_head; exp_b[10] = act_sec;
      if (f[1:0] == 2'b11) begin
        exp_b[0][6] = 1'b1;
        readout("R8", 1'b0, 1'b0);
      end else begin
        readout("R7", f[2], 1'b0);
      end
    end
    // R7: last load wins
    clear_cmd();
    act_load = 1'b1; act_cyl = 12'hABC; act_flags = 4'h4; act_head = 8'h11; act_sec = 8'h22;
    cyc();
    act_cyl = 12'h5D6; act_flags = 4'h8; act_head = 8'h33; act_sec = 8'h44;
    cyc();
    act_load = 1'b0;
    exp_b[7] = 8'hD6; exp_b[8] = 8'h85; exp_b[9] = 8'h33; exp_b[10] = 8'h44;
    readout("R7", 1'b0, 1'b0);

    // R9: retry counting and saturation
    clear_cmd();
    retry_inc = 1'b1; repeat (5) cyc(); retry_inc = 1'b0;
    exp_b[11] = 8'd5;
    readout("R9", 1'b0, 1'b0);
    clear_cmd();
    retry_inc = 1'b1; repeat (300) cyc(); retry_inc = 1'b0;
    exp_b[11] = 8'hFF;
    readout("R9", 1'b1, 1'b0);

    // R1: events coinciding with a clearing start are dropped
    pulse_hard(12);
    cmd_start = 1'b1; cmd_func = 8'h07; hard_evt = 1'b1; hard_code = 4'd9;
    retry_inc = 1'b1; des_load = 1'b1; des_cyl = 16'hBEEF;
    cyc();
    cmd_start = 1'b0; hard_evt = 1'b0; retry_inc = 1'b0; des_load = 1'b0;
    model_clear();
    readout("R1", 1'b0, 1'b0);

    // R2: transfer start keeps contents, accumulation continues
    pulse_hard(4);
    readout("R2", 1'b0, 1'b0);
    pulse_hard(10);
    soft_evt = 1'b1; soft_code = 3'd7; cyc(); soft_evt = 1'b0;
    exp_b[2][7] = 1'b1;
    readout("R2", 1'b1, 1'b0);

    // R11: back-to-back readouts agree; R10: start while streaming ignored
    des_load = 1'b1; des_cyl = 16'h0102; des_head = 8'h03; des_sec = 8'h04; cyc(); des_load = 1'b0;
    exp_b[3] = 8'h02; exp_b[4] = 8'h01; exp_b[5] = 8'h03; exp_b[6] = 8'h04;
    readout("R11", 1'b0, 1'b0);
    readout("R11", 1'b1, 1'b0);
    readout("R10", 1'b0, 1'b1);
    readout("R10", 1'b1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule